// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block collects interrupt requests from a set of peripheral lines and offers the single most urgent one to a processor core. Each line has three settings: an enable, a pending flag and an 8-bit priority field. A line becomes pending on a rising edge of its hardware request or on a software trigger write. Software can also clear a pending flag by a write. A smaller priority number is more urgent, and only the top three bits of each priority field are kept.

Two global controls gate all lines. A one-bit global disable stops every line from being offered. A base-priority threshold blocks each line whose priority is equal to or worse than the threshold, and a threshold of zero blocks nothing. Lines set pending by software obey exactly the same masking as lines set pending by hardware. A separate stack of active priorities lets a new line interrupt a running handler only when the new line is strictly more urgent. The core answers with an acknowledge, which clears the line's pending flag and pushes its priority onto the stack, and with a return, which pops the stack. Acknowledge never changes the threshold.

The request and vector outputs are registered. They reflect the controller state of the previous cycle and are forced low in any cycle that follows an acknowledge or a return.

Top module: `pmic_top`

## Requirements
- R1: After reset, every enable, pending flag, priority field, the threshold and the global disable read zero, and `irq_req` is low.
- R2: A priority write keeps only data bits [7:5]. A read of the priority field returns those bits in [7:5] with [4:0] zero, so any written value below 32 reads back as zero.
- R3: A rising edge on `hw_req[i]` sets line i pending. A level held high does not pend the line again after it has been taken, and edges that arrive while the line is already pending merge into one pend.
- R4: A software trigger write (wr_kind 2) sets the named line pending, and that pend is masked exactly like a hardware pend.
- R5: A pend-clear write (wr_kind 3) clears the named line's pending flag, and the line is no longer requested.
- R6: While the threshold is nonzero, a line whose stored priority is greater than or equal to the threshold is not requested. Raising the threshold above the line's priority releases the line.
- R7: A threshold of zero masks nothing, so the lowest stored priority (7) is still requested.
- R8: While the global disable (wr_kind 5, read kind 4, data bit 0 only) is set, `irq_req` stays low. Writing 0xFE leaves the disable clear.
- R9: Only lines that are both enabled and pending compete. The lowest stored priority wins, and on a tie the lowest line index wins. `irq_vec` carries the winner's index, and both outputs follow the state one cycle later.
- R10: An acknowledge while `irq_req` is high clears the pending flag of `irq_vec` and pushes that line's priority onto the active stack. `irq_req` is low in the cycle that follows.
- R11: While a handler is active, a line is requested only if its priority is strictly smaller than the top of the active stack. A line with equal priority waits.
- R12: A return pops the active stack, which restores the previous active level. Lines that were held back are then requested.
- R13: An acknowledge does not load the threshold. A threshold read inside a handler returns the last written value.

Write kinds: 0 enable (bit 0), 1 priority, 2 software trigger, 3 pend clear, 4 threshold, 5 global disable. Read kinds: 0 enable, 1 priority, 2 pending, 3 threshold, 4 global disable. Single-bit reads return their value in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Write kind code |
| wr_line | input | LINE_W | Line addressed by the write |
| wr_data | input | 8 | Write data |
| rd_kind | input | 3 | Read kind code |
| rd_line | input | LINE_W | Line addressed by the read |
| rd_data | output | 8 | Registered read data, valid one cycle after the read kind and line are applied |
| hw_req | input | NUM_LINES | Hardware request levels, one per line |
| ack | input | 1 | Core takes the offered interrupt |
| ret | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_vec | output | LINE_W | Index of the offered line |

## Verification
Some rules are checked by the assertions in every cycle. The global disable must keep the request low. The request must fall after an acknowledge. The arbiter's winner must beat both a nonzero threshold and the top of the active stack. Priority reads must never return low bits, and the stack depth must step correctly. Other behaviour shows only in the bench's scenarios: which line wins a tie, edge merging, release of a masked software pend when the threshold is raised, and the level restored after nested returns. The bench checks these through the ports.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    WK_ENABLE   = 3'd0,
    WK_PRIO     = 3'd1,
    WK_PEND_SET = 3'd2,
    WK_PEND_CLR = 3'd3,
    WK_THRESH   = 3'd4,
    WK_GDIS     = 3'd5
  } wr_kind_e;

  typedef enum logic [2:0] {
    RK_ENABLE = 3'd0,
    RK_PRIO   = 3'd1,
    RK_PEND   = 3'd2,
    RK_THRESH = 3'd3,
    RK_GDIS   = 3'd4
  } rd_kind_e;
endpackage

// File: rtl/pmic_regs.sv
module pmic_regs
  import pmic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 3,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int LOW_W  = REG_W - PRIO_BITS
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [2:0]                           wr_kind,
  input  logic [LINE_W-1:0]                    wr_line,
  input  logic [REG_W-1:0]                     wr_data,
  input  logic [2:0]                           rd_kind,
  input  logic [LINE_W-1:0]                    rd_line,
  output logic [REG_W-1:0]                     rd_data,
  input  logic [NUM_LINES-1:0]                 hw_req,
  input  logic                                 clr_en,
  input  logic [LINE_W-1:0]                    clr_line,
  output logic [NUM_LINES-1:0]                 en_o,
  output logic [NUM_LINES-1:0]                 pend_o,
  output logic [NUM_LINES-1:0][PRIO_BITS-1:0]  prio_o,
  output logic [PRIO_BITS-1:0]                 thr_o,
  output logic                                 gdis_o
);
  logic [NUM_LINES-1:0] hw_q;
  logic [NUM_LINES-1:0] pend_set, pend_clr;

  // Per-line pend set/clear terms
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign pend_set[i] = (hw_req[i] & ~hw_q[i]) |
                         (wr_en && wr_kind == WK_PEND_SET && wr_line == LINE_W'(i));
    assign pend_clr[i] = (wr_en && wr_kind == WK_PEND_CLR && wr_line == LINE_W'(i)) |
                         (clr_en && clr_line == LINE_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_q   <= '0;
      en_o   <= '0;
      pend_o <= '0;
      prio_o <= '0;
      thr_o  <= '0;
      gdis_o <= 1'b0;
    end else begin
      hw_q   <= hw_req;
      pend_o <= (pend_o & ~pend_clr) | pend_set;
      if (wr_en) begin
        case (wr_kind)
          WK_ENABLE: en_o[wr_line]   <= wr_data[0];
          WK_PRIO:   prio_o[wr_line] <= wr_data[REG_W-1 -: PRIO_BITS];
          WK_THRESH: thr_o           <= wr_data[REG_W-1 -: PRIO_BITS];
          WK_GDIS:   gdis_o          <= wr_data[0];
          default:   ;
        endcase
      end
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_kind)
        RK_ENABLE: rd_data <= {{(REG_W-1){1'b0}}, en_o[rd_line]};
        RK_PRIO:   rd_data <= {prio_o[rd_line], {LOW_W{1'b0}}};
        RK_PEND:   rd_data <= {{(REG_W-1){1'b0}}, pend_o[rd_line]};
        RK_THRESH: rd_data <= {thr_o, {LOW_W{1'b0}}};
        RK_GDIS:   rd_data <= {{(REG_W-1){1'b0}}, gdis_o};
        default:   rd_data <= '0;
      endcase
    end
  end

  AST_PRIO_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_kind == RK_PRIO) |=> (rd_data[LOW_W-1:0] == '0)); // R2
endmodule

// File: rtl/pmic_pick.sv
module pmic_pick #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 3,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]                en,
  input  logic [NUM_LINES-1:0]                pend,
  input  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio,
  input  logic [PRIO_BITS-1:0]                thr,
  input  logic                                gdis,
  input  logic                                act_valid,
  input  logic [PRIO_BITS-1:0]                act_prio,
  output logic                                sel_valid,
  output logic [LINE_W-1:0]                   sel_line,
  output logic [PRIO_BITS-1:0]                sel_prio
);
  logic [NUM_LINES-1:0] elig;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_elig
    assign elig[i] = en[i] & pend[i] & ~gdis &
                     ((thr == '0) || (prio[i] < thr)) &
                     (!act_valid || (prio[i] < act_prio));
  end

  // Lowest priority value wins; strict compare keeps the lower index on ties
  always_comb begin
    sel_valid = 1'b0;
    sel_line  = '0;
    sel_prio  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig[i] && (!sel_valid || prio[i] < sel_prio)) begin
        sel_valid = 1'b1;
        sel_line  = LINE_W'(i);
        sel_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/pmic_active_stack.sv
module pmic_active_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_val,
  output logic [WIDTH-1:0] top_val,
  output logic             valid,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    cnt;
  logic             pop_ok, push_ok;
  logic [CW-1:0]    wr_pos;

  assign valid   = (cnt != '0);
  assign full    = (cnt == CW'(DEPTH));
  assign pop_ok  = pop & valid;
  assign push_ok = push & (!full | pop_ok);
  assign wr_pos  = cnt - CW'(pop_ok);
  assign top_val = valid ? mem[AW'(cnt - CW'(1))] : '0;

  always_ff @(posedge clk) begin
    if (push_ok) mem[AW'(wr_pos)] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> !full); // R11

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (rst)
    (pop && valid && !push) |=> (cnt == $past(cnt) - CW'(1))); // R12
endmodule

// File: rtl/pmic_top.sv
module pmic_top
  import pmic_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int PRIO_BITS   = 3,
  parameter int STACK_DEPTH = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           wr_kind,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [2:0]           rd_kind,
  input  logic [LINE_W-1:0]    rd_line,
  output logic [REG_W-1:0]     rd_data,
  input  logic [NUM_LINES-1:0] hw_req,
  input  logic                 ack,
  input  logic                 ret,
  output logic                 irq_req,
  output logic [LINE_W-1:0]    irq_vec
);
  logic [NUM_LINES-1:0]                en, pend;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio;
  logic [PRIO_BITS-1:0]                thr, act_prio, sel_prio;
  logic                                gdis, act_valid, act_full, sel_valid, take;
  logic [LINE_W-1:0]                   sel_line;

  assign take = ack & irq_req;

  pmic_regs #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_line(wr_line), .wr_data(wr_data),
    .rd_kind(rd_kind), .rd_line(rd_line), .rd_data(rd_data),
    .hw_req(hw_req), .clr_en(take), .clr_line(irq_vec),
    .en_o(en), .pend_o(pend), .prio_o(prio), .thr_o(thr), .gdis_o(gdis)
  );

  pmic_pick #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) pick_i (
    .en(en), .pend(pend), .prio(prio), .thr(thr), .gdis(gdis),
    .act_valid(act_valid), .act_prio(act_prio),
    .sel_valid(sel_valid), .sel_line(sel_line), .sel_prio(sel_prio)
  );

  pmic_active_stack #(.DEPTH(STACK_DEPTH), .WIDTH(PRIO_BITS)) stack_i (
    .clk(clk), .rst(rst),
    .push(take), .pop(ret), .push_val(prio[irq_vec]),
    .top_val(act_prio), .valid(act_valid), .full(act_full)
  );

  // Registered offer; dropped for one cycle after any ack or return
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= sel_valid & ~ack & ~ret & ~act_full;
      irq_vec <= sel_line;
    end
  end

  AST_GDIS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    gdis |=> !irq_req); // R8

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq_req); // R10

  AST_THRESH_MASK: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && thr != '0) |-> (sel_prio < thr)); // R6

  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && act_valid) |-> (sel_prio < act_prio)); // R11
endmodule

// File: tb/pmic_top_tb_top.sv
module pmic_top_tb_top;
  localparam int N  = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_kind = '0;
  logic [LW-1:0] wr_line = '0;
  logic [7:0]    wr_data = '0;
  logic [2:0]    rd_kind = '0;
  logic [LW-1:0] rd_line = '0;
  logic [7:0]    rd_data;
  logic [N-1:0]  hw_req = '0;
  logic          ack = 1'b0;
  logic          ret = 1'b0;
  logic          irq_req;
  logic [LW-1:0] irq_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  pmic_top #(.NUM_LINES(N), .PRIO_BITS(3), .STACK_DEPTH(8)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_line(wr_line),
    .wr_data(wr_data), .rd_kind(rd_kind), .rd_line(rd_line), .rd_data(rd_data),
    .hw_req(hw_req), .ack(ack), .ret(ret), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] k, input int l, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_line = LW'(l); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] k, input int l, output int v);
    rd_kind = k; rd_line = LW'(l);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // Driver: record the expected vector, then acknowledge
  task automatic take(string req, input int exp_vec);
    exp_q.push_back(exp_vec);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R10 req low after ack", int'(irq_req), 0);
    @(negedge clk);
  endtask

  task automatic do_ret();
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_req(string req, input int r);
    check(req, int'(irq_req), r);
  endtask

  task automatic expect_vec(string req, input int v);
    check(req, int'(irq_req), 1);
    check(req, int'(irq_vec), v);
  endtask

  // Monitor: sample just before each rising edge
  always begin
    @(negedge clk);
    #4;
    if (!rst && ack) begin
      checks++;
      if (!irq_req || exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 ack without offer: actual req %0d expected 1", irq_req);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(irq_vec) != e) begin
          fails++;
          $display("FAIL R9 taken vector: actual %0d expected %0d", irq_vec, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_req("R1 irq_req", 0);
    rd(3, 0, v); check("R1 threshold", v, 0);
    rd(1, 3, v); check("R1 priority", v, 0);
    rd(4, 0, v); check("R1 disable", v, 0);
    rd(2, 0, v); check("R1 pending", v, 0);
    rd(0, 0, v); check("R1 enable", v, 0);

    // R2 priority truncation
    wr(1, 2, 8'hFF); rd(1, 2, v); check("R2 0xFF", v, 8'hE0);
    wr(1, 2, 8'h1F); rd(1, 2, v); check("R2 0x1F", v, 8'h00);
    wr(1, 2, 8'h3F); rd(1, 2, v); check("R2 0x3F", v, 8'h20);

    for (int i = 0; i < 5; i++) wr(0, i, 8'h01);
    wr(1, 0, 8'hE0); wr(1, 1, 8'h80); wr(1, 3, 8'h00); wr(1, 4, 8'h20);

    // R4/R6 software pend masked by threshold 7
    wr(4, 0, 8'hE0);
    wr(2, 0, 8'h00);
    expect_req("R4 sw pend masked", 0);
    rd(2, 0, v); check("R4 pend held", v, 1);
    // R7 zero threshold releases priority 7
    wr(4, 0, 8'h00);
    expect_vec("R7 zero threshold", 0);
    take("R7", 0); do_ret();

    // R6 threshold 4 blocks priority 4, threshold 5 releases it
    wr(4, 0, 8'h80);
    wr(2, 1, 8'h00);
    expect_req("R6 equal blocked", 0);
    wr(4, 0, 8'hA0);
    expect_vec("R6 raised threshold", 1);
    take("R6", 1); do_ret();
    wr(4, 0, 8'h00);

    // R9 priority order, then R11 equal-level hold
    wr(2, 1, 8'h00); wr(2, 2, 8'h00);
    expect_vec("R9 lower value wins", 2);
    take("R9", 2);
    expect_req("R11 less urgent waits", 0);
    do_ret();
    expect_vec("R12 released after return", 1);
    take("R12", 1); do_ret();

    // R9 tie broken by index
    wr(2, 4, 8'h00); wr(2, 2, 8'h00);
    expect_vec("R9 tie lowest index", 2);
    take("R9 tie", 2);
    expect_req("R11 equal priority waits", 0);
    do_ret();
    expect_vec("R12 tie loser after return", 4);
    take("R12", 4); do_ret();

    // R9 disabled line, R5 pend clear
    wr(2, 5, 8'h00);
    expect_req("R9 disabled line", 0);
    rd(2, 5, v); check("R9 disabled still pending", v, 1);
    wr(3, 5, 8'h00);
    rd(2, 5, v); check("R5 pend cleared", v, 0);

    // R11/R12 nesting
    wr(2, 1, 8'h00);
    take("R11 outer", 1);
    wr(2, 4, 8'h00);
    expect_vec("R11 preempt", 4);
    take("R11 inner", 4);
    wr(2, 2, 8'h00);
    expect_req("R11 equal to active", 0);
    do_ret();
    expect_vec("R12 level restored", 2);
    take("R12", 2);
    do_ret(); do_ret();
    expect_req("R12 idle", 0);

    // R13 threshold unchanged by ack
    wr(4, 0, 8'hC0);
    wr(2, 3, 8'h00);
    take("R13", 3);
    rd(3, 0, v); check("R13 threshold in handler", v, 8'hC0);
    do_ret();
    wr(4, 0, 8'h00);

    // R8 global disable
    wr(5, 0, 8'hFE); rd(4, 0, v); check("R8 bit0 only", v, 0);
    wr(5, 0, 8'h01); rd(4, 0, v); check("R8 set", v, 1);
    wr(2, 3, 8'h00);
    expect_req("R8 blocked", 0);
    wr(5, 0, 8'h00);
    expect_vec("R8 released", 3);
    take("R8", 3); do_ret();

    // R5 clear removes offer
    wr(2, 1, 8'h00);
    expect_vec("R5 before clear", 1);
    wr(3, 1, 8'h00);
    expect_req("R5 after clear", 0);

    // R3 hardware edge
    hw_req[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_vec("R3 edge pends", 3);
    take("R3", 3); do_ret();
    expect_req("R3 held level no repend", 0);
    rd(2, 3, v); check("R3 no repend", v, 0);
    hw_req[3] = 1'b0;
    wr(5, 0, 8'h01);
    for (int p = 0; p < 2; p++) begin
      hw_req[3] = 1'b1; @(negedge clk);
      hw_req[3] = 1'b0; @(negedge clk);
    end
    wr(5, 0, 8'h00);
    expect_vec("R3 merged pend", 3);
    take("R3 merged", 3); do_ret();
    expect_req("R3 single pend", 0);

    repeat (3) @(negedge clk);
    check("R10 all acks matched", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule